// File: doc/BRIEF.md
# Multi-Mode Addressable Bit Latch

This block keeps eight single-bit storage cells. A three-bit address picks one cell and a serial data bit is written into it. Two active-low control inputs, an enable and a clear, select one of four modes together. In write mode the addressed cell takes the data bit and the other seven keep their values. In hold mode nothing changes and the data and address inputs are ignored. With both controls low the block acts as an active-high 1-of-8 demultiplexer: the addressed output shows the data bit and every other output is low. With the data bit tied high this gives a one-hot decoder. In clear mode every output is low, whatever the address and data inputs are.

The block is a clocked synchronous model. In place of a transparent latch there is a register array that updates on the rising system clock edge. So a write shows on the outputs from the cycle after the edge. The demultiplex and clear outputs are combinational and appear in the same cycle as the mode. Both of these modes also zero the stored array at the next edge, so a later return to hold mode reads all zeros. Address changes should be made in hold mode. Outside hold mode, each clock edge acts on whatever address is present at that edge.

Top module: `addr_latch`

## Requirements
- R1: When rst_n is low at a rising clock edge, all stored bits become zero. After that, hold mode reads q == 0.
- R2: Write mode is en_n = 0 and clr_n = 1. At a rising edge in this mode, the stored bit selected by addr takes the value of d. The outputs show the stored array, so the new value appears on q after that edge.
- R3: In write mode, every stored bit other than the addressed one keeps its value across the edge.
- R4: Hold mode is en_n = 1 and clr_n = 1. In this mode the stored array does not change and q equals the stored array, whatever d and addr do.
- R5: Demultiplex mode is en_n = 0 and clr_n = 0. In this mode q has the value of d at bit position addr and zero at every other bit, in the same cycle with no clock edge needed.
- R6: A rising edge in demultiplex mode clears every stored bit. A following hold cycle reads q == 0.
- R7: Clear mode is en_n = 1 and clr_n = 0. In this mode q is zero in the same cycle for any d and addr, and a rising edge in this mode clears every stored bit.
- R8: Address value k selects output bit q[k]. Address 0 maps to q[0] and address 7 maps to q[7].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the stored array |
| en_n | input | 1 | Active-low enable; selects the mode together with clr_n |
| clr_n | input | 1 | Active-low clear; selects the mode together with en_n |
| d | input | 1 | Serial data bit |
| addr | input | ADDR_W (3) | Selects the cell or output |
| q | output | 2**ADDR_W (8) | Parallel outputs |

## Verification
The hardest case to reach is a demultiplex or clear cycle that sits between two hold cycles. The output bus in that cycle is built from the inputs and does not reflect the stored bits. The effect on the stored array only shows once the bench goes back to hold. So the stimulus first fills the array with a known non-zero pattern through write cycles. It then enters demultiplex or clear mode for a single edge, with addr and d moving, and then returns to hold. In that hold cycle any cell that was not cleared shows up directly on q. A long stretch of random mode, address and data sequences follows, with every cycle compared against a behavioural model in the bench.

// File: rtl/addr_latch_pkg.sv
// Package: shared mode type and helper for the addressable latch.
// Assumes active-low enable and clear inputs.
package addr_latch_pkg;

    typedef enum logic [1:0] {
        MODE_WRITE = 2'd0,
        MODE_HOLD  = 2'd1,
        MODE_DEMUX = 2'd2,
        MODE_CLEAR = 2'd3
    } op_mode_t;

    // Map the two active-low controls onto an operating mode.
    function automatic op_mode_t pick_mode(input logic en_n, input logic clr_n);
        op_mode_t m;
        case ({clr_n, en_n})
            2'b10:   m = MODE_WRITE;
            2'b11:   m = MODE_HOLD;
            2'b00:   m = MODE_DEMUX;
            default: m = MODE_CLEAR;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/alatch_mode_dec.sv
// Module: alatch_mode_dec
// Turns the enable and clear inputs into one mode value.
// Assumes both inputs are synchronous to the system clock.
module alatch_mode_dec
    import addr_latch_pkg::*;
(
    input  logic     en_n,
    input  logic     clr_n,
    output op_mode_t mode
);

    // Combinational mode selection.
    always_comb begin
        mode = pick_mode(en_n, clr_n);
    end

endmodule

// File: rtl/alatch_onehot.sv
// Module: alatch_onehot
// Builds a one-hot select from the address, and the same vector gated by
// the data bit for demultiplexing. Bit k belongs to address value k.
module alatch_onehot #(
    parameter int ADDR_W = 3,
    localparam int NUM_BITS = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                d,
    output logic [NUM_BITS-1:0] sel,
    output logic [NUM_BITS-1:0] demux_vec
);

    genvar k;
    generate
        for (k = 0; k < NUM_BITS; k++) begin : g_slot
            // Compare the address with this slot's index.
            always_comb begin
                sel[k]       = (addr == ADDR_W'(k));
                demux_vec[k] = sel[k] & d;
            end
        end
    endgenerate

endmodule

// File: rtl/alatch_store.sv
// Module: alatch_store
// Register array of NUM_BITS cells. A write updates only the selected
// cell, demultiplex and clear modes zero every cell, and hold keeps them.
// Assumes sel is one-hot. Reset is synchronous and active-low.
module alatch_store
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NUM_BITS = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  op_mode_t            mode,
    input  logic [NUM_BITS-1:0] sel,
    input  logic                d,
    output logic [NUM_BITS-1:0] store_q
);

    genvar k;
    generate
        for (k = 0; k < NUM_BITS; k++) begin : g_cell
            // Per-cell update chosen by the mode.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store_q[k] <= 1'b0;
                end else begin
                    case (mode)
                        MODE_WRITE: if (sel[k]) store_q[k] <= d;
                        MODE_HOLD:  store_q[k] <= store_q[k];
                        default:    store_q[k] <= 1'b0;
                    endcase
                end
            end
        end
    endgenerate

    // R2: the selected cell takes d.
    p_write_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |=> (((store_q & $past(sel)) != '0) == $past(d)));

    // R3: cells that were not selected keep their values.
    p_write_others_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_WRITE) |=> (((store_q ^ $past(store_q)) & ~$past(sel)) == '0));

    // R4: hold leaves the array unchanged.
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD) |=> $stable(store_q));

    // R6 and R7: demultiplex and clear zero the array.
    p_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_DEMUX || mode == MODE_CLEAR) |=> (store_q == '0));

endmodule

// File: rtl/alatch_out_mux.sv
// Module: alatch_out_mux
// Chooses the output bus: the stored array in write and hold modes, the
// data-gated one-hot in demultiplex mode, and zero in clear mode.
module alatch_out_mux
    import addr_latch_pkg::*;
#(
    parameter int NUM_BITS = 8
) (
    input  op_mode_t            mode,
    input  logic [NUM_BITS-1:0] store_q,
    input  logic [NUM_BITS-1:0] demux_vec,
    output logic [NUM_BITS-1:0] q
);

    // Output selection by mode.
    always_comb begin
        case (mode)
            MODE_DEMUX: q = demux_vec;
            MODE_CLEAR: q = '0;
            default:    q = store_q;
        endcase
    end

endmodule

// File: rtl/addr_latch.sv
// Module: addr_latch (top)
// Clocked addressable latch with four modes chosen by en_n and clr_n:
// write, hold, demultiplex and clear. Assumes all inputs are synchronous
// to clk. The address should only change in hold mode.
module addr_latch
    import addr_latch_pkg::*;
#(
    parameter int ADDR_W = 3,
    localparam int NUM_BITS = 1 << ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_n,
    input  logic                clr_n,
    input  logic                d,
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_BITS-1:0] q
);

    op_mode_t            mode;
    logic [NUM_BITS-1:0] sel;
    logic [NUM_BITS-1:0] demux_vec;
    logic [NUM_BITS-1:0] store_q;

    alatch_mode_dec u_mode (
        .en_n  (en_n),
        .clr_n (clr_n),
        .mode  (mode)
    );

    alatch_onehot #(.ADDR_W(ADDR_W)) u_hot (
        .addr      (addr),
        .d         (d),
        .sel       (sel),
        .demux_vec (demux_vec)
    );

    alatch_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode),
        .sel     (sel),
        .d       (d),
        .store_q (store_q)
    );

    alatch_out_mux #(.NUM_BITS(NUM_BITS)) u_mux (
        .mode      (mode),
        .store_q   (store_q),
        .demux_vec (demux_vec),
        .q         (q)
    );

    // R5: in demultiplex mode at most one output is high, and only if d is high.
    p_demux_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !clr_n) |-> ($onehot0(q) && (d || q == '0)));

    // R7: in clear mode the outputs are low.
    p_clear_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_n && !clr_n) |-> (q == '0));

endmodule

// File: tb/tb_addr_latch.sv
// Bench for addr_latch: a behavioural model compared against the outputs every cycle.
module tb_addr_latch;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1;
    logic       clr_n = 1'b1;
    logic       d = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] q;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] model = 8'h00;
    int prev_op = 1; // 0 write, 1 hold/reset, 2 demux, 3 clear
    logic [2:0] prev_addr = 3'd0;

    always #10 clk = ~clk;

    addr_latch dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .clr_n(clr_n),
        .d(d), .addr(addr), .q(q)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: q=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model at the rising edge.
    task automatic step(input logic en_i, input logic clr_i, input logic d_i, input logic [2:0] a_i);
        int op;
        logic [7:0] mask;
        @(negedge clk);
        en_n = en_i; clr_n = clr_i; d = d_i; addr = a_i;
        #2;
        op = (!clr_i) ? (en_i ? 3 : 2) : (en_i ? 1 : 0);
        if (op == 2) begin
            check("R5", q, 8'(d_i) << a_i);
        end else if (op == 3) begin
            check("R7", q, 8'h00);
        end else begin
            case (prev_op)
                0: begin
                    mask = 8'h01 << prev_addr;
                    check("R2", q & mask, model & mask);
                    check("R3", q & ~mask, model & ~mask);
                end
                2: check("R6", q, model);
                3: check("R7", q, model);
                default: check("R4", q, model);
            endcase
        end
        @(posedge clk);
        case (op)
            0: model[a_i] = d_i;
            2, 3: model = 8'h00;
            default: ;
        endcase
        prev_op = op;
        prev_addr = a_i;
    endtask

    // Watchdog: an expired timer is a failed check.
    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: q=%h expected completion", q);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: write attempts during reset are discarded.
        en_n = 1'b0; d = 1'b1; addr = 3'd4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1; en_n = 1'b1;
        #2;
        check("R1", q, 8'h00);

        // Fill the array through write mode at every address.
        for (int a = 0; a < 8; a++) step(1'b0, 1'b1, a[0] ^ a[2], 3'(a));
        // Hold with d and addr moving.
        for (int a = 0; a < 8; a++) step(1'b1, 1'b1, ~a[0], 3'(7 - a));
        // Overwrite every cell with 1, then clear alternate cells.
        for (int a = 0; a < 8; a++) step(1'b0, 1'b1, 1'b1, 3'(a));
        for (int a = 0; a < 8; a += 2) step(1'b0, 1'b1, 1'b0, 3'(a));
        step(1'b1, 1'b1, 1'b0, 3'd0);

        // Demultiplex with d = 1 and d = 0 at every address, then return to hold.
        for (int a = 0; a < 8; a++) begin
            step(1'b0, 1'b1, 1'b1, 3'(a));
            step(1'b0, 1'b0, 1'b1, 3'(a));
            step(1'b0, 1'b0, 1'b0, 3'(a));
            step(1'b1, 1'b1, 1'b1, 3'(a));
        end

        // Clear overriding the inputs at every address.
        for (int a = 0; a < 8; a++) begin
            step(1'b0, 1'b1, 1'b1, 3'(a));
            step(1'b0, 1'b1, 1'b1, 3'(7 - a));
            step(1'b1, 1'b0, a[0], 3'(a));
            step(1'b1, 1'b1, 1'b1, 3'(a));
        end

        // R8: address 5 maps to q[5] and address 0 to q[0].
        step(1'b0, 1'b1, 1'b1, 3'd5);
        step(1'b1, 1'b1, 1'b0, 3'd0);
        check("R8", q, 8'h20);
        step(1'b0, 1'b0, 1'b1, 3'd0);
        check("R8", q, 8'h01);
        step(1'b0, 1'b0, 1'b1, 3'd7);
        check("R8", q, 8'h80);

        // Random mode, address and data sequence.
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0], r[1] | r[2], r[3], r[6:4]);
        end

        // R1: a reset in mid-run clears a non-zero array.
        step(1'b0, 1'b1, 1'b1, 3'd3);
        @(negedge clk);
        rst_n = 1'b0; en_n = 1'b1; clr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R1", q, 8'h00);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule